// File: doc/BRIEF.md
# Interrupt Status Aggregator

This block collects interrupt requests from a set of GPIO banks and from a group of other on-chip peripherals, and presents them as a single status word and a single interrupt line to the host processor. Each GPIO bank gives one pending line that has already been qualified by the bank's own masking. Each peripheral gives a raw request line, and the block gates that line with a per-source enable bit held in its own enable register.

The host reaches the status word and the enable register through a small 16-bit register port. The host input that receives the interrupt line is rising-edge sensitive. On each edge the host reads the status word, services every source that shows a 1, and reads again until the word is zero. The output therefore returns low once nothing is pending, so that the next event gives a new rising edge. The enable register also holds one global enable bit, which initialisation software sets. While that bit is clear the output stays low, but the status word still shows what is pending.

Top module: `irq_aggregator`

## Requirements
- R1: After a synchronous active-low reset, the status word reads 0, the enable register reads 0 and irq_o is low.
- R2: Status bits 0 to 3 show the pending lines of GPIO banks 0 to 3, one clock after the lines are sampled.
- R3: Peripheral source k (k = 0 to 5) appears at status bit 4+k, one clock after it is sampled, when enable bit k is 1.
- R4: A peripheral whose enable bit is 0 reads as 0 in the status word, whatever its request line does.
- R5: The enable register is at address 1. Bits 0 to 5 are the peripheral enables and bit 15 is the global enable. A write stores these bits, and every other bit reads back as 0.
- R6: The status word is at address 0 and is read-only. A write to address 0 changes neither the status word nor the enable register.
- R7: irq_o goes high one clock after a cycle in which the global enable is 1 and the status word is non-zero.
- R8: While the global enable is 0, irq_o is low even if the status word is non-zero.
- R9: irq_o is low in the clock after the status word is zero, so a later event produces a new rising edge.
- R10: The GPIO bank status bits do not depend on the peripheral enable bits or on the global enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bank_pend_i | input | 4 | Pending line from each GPIO bank |
| periph_req_i | input | 6 | Raw request line from each peripheral source |
| reg_addr_i | input | 2 | Register select: 0 for status, 1 for enable |
| reg_wr_i | input | 1 | Write strobe for the register port |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for the selected register (combinational) |
| irq_o | output | 1 | Interrupt line to the host |

## Verification
The bench builds the block with its defaults: four banks, six peripherals and a 16-bit register port. At these values the global enable sits at bit 15, far from the peripheral enables, so a write of all ones shows that the unused middle bits read back as zero. The stimulus drives the first and the last peripheral together, which checks both ends of the 4+k mapping. Disabling one of them while its request stays high shows the enable gating. The output is traced through a full cycle: it drops when the status word clears and rises again on the next event.

// File: rtl/irq_agg_pkg.sv
// Shared definitions for the interrupt status aggregator.
// Assumes a register port with two address bits; unused addresses read zero.
package irq_agg_pkg;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_STATUS = 2'd0,
        REG_ENABLE = 2'd1
    } reg_sel_e;
endpackage

// File: rtl/irq_status_merge.sv
// Builds the registered status word: bank pending lines in the low bits,
// enabled peripheral requests above them. Assumes the bank lines are
// already qualified upstream and the request lines are synchronous.
module irq_status_merge #(
    parameter int NUM_BANKS  = 4,
    parameter int NUM_PERIPH = 6,
    localparam int STAT_W    = NUM_BANKS + NUM_PERIPH
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_BANKS-1:0]  bank_pend_i,
    input  logic [NUM_PERIPH-1:0] periph_req_i,
    input  logic [NUM_PERIPH-1:0] periph_en_i,
    output logic [STAT_W-1:0]     status_o
);
    logic [NUM_PERIPH-1:0] gated_req;
    logic [STAT_W-1:0]     status_q;

    // One gate per peripheral source: the request passes only when its enable is set.
    for (genvar k = 0; k < NUM_PERIPH; k++) begin : g_gate
        assign gated_req[k] = periph_req_i[k] & periph_en_i[k];
    end

    // Capture the merged status word on each clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
        end else begin
            status_q <= {gated_req, bank_pend_i};
        end
    end

    assign status_o = status_q;
endmodule

// File: rtl/irq_enable_reg.sv
// Holds the enable register. Only the peripheral enable bits and the
// global enable bit can be written; every other bit stays zero.
// Assumes the write strobe has already been decoded for this address.
module irq_enable_reg #(
    parameter int NUM_PERIPH = 6,
    parameter int REG_W      = 16,
    localparam int GLOBAL_BIT = REG_W - 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en_i,
    input  logic [REG_W-1:0]      wr_data_i,
    output logic [REG_W-1:0]      en_reg_o,
    output logic [NUM_PERIPH-1:0] periph_en_o,
    output logic                  global_en_o
);
    logic [REG_W-1:0] writable;
    logic [REG_W-1:0] en_q;

    // Mark which bits of the register can be written.
    always_comb begin
        writable                   = '0;
        writable[NUM_PERIPH-1:0]   = '1;
        writable[GLOBAL_BIT]       = 1'b1;
    end

    // Store the writable bits on a write; reset leaves every source disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (wr_en_i) begin
            en_q <= wr_data_i & writable;
        end
    end

    assign en_reg_o    = en_q;
    assign periph_en_o = en_q[NUM_PERIPH-1:0];
    assign global_en_o = en_q[GLOBAL_BIT];
endmodule

// File: rtl/irq_out_gen.sv
// Drives the interrupt line to the host. The line is high while the global
// enable is set and any status bit is 1, and it falls one clock after the
// status word clears. Assumes the host input is rising-edge sensitive.
module irq_out_gen #(
    parameter int STAT_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              global_en_i,
    input  logic [STAT_W-1:0] status_i,
    output logic              irq_o
);
    logic irq_q;

    // Register the qualified OR of the status word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= global_en_i & (|status_i);
        end
    end

    assign irq_o = irq_q;
endmodule

// File: rtl/irq_aggregator.sv
// Top level of the interrupt status aggregator. It merges the GPIO bank
// pending lines and the enabled peripheral requests into one status word,
// holds the enable register and drives a single interrupt line.
// Assumes all inputs are synchronous to clk.
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int NUM_BANKS  = 4,
    parameter int NUM_PERIPH = 6,
    parameter int REG_W      = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_BANKS-1:0]  bank_pend_i,
    input  logic [NUM_PERIPH-1:0] periph_req_i,
    input  logic [ADDR_W-1:0]     reg_addr_i,
    input  logic                  reg_wr_i,
    input  logic [REG_W-1:0]      reg_wdata_i,
    output logic [REG_W-1:0]      reg_rdata_o,
    output logic                  irq_o
);
    localparam int STAT_W = NUM_BANKS + NUM_PERIPH;

    logic [NUM_PERIPH-1:0] periph_en;
    logic                  global_en;
    logic [REG_W-1:0]      en_reg;
    logic [STAT_W-1:0]     status;
    logic                  en_wr;

    // Decode a write to the enable register; writes elsewhere are dropped.
    always_comb begin
        en_wr = reg_wr_i && (reg_addr_i == REG_ENABLE);
    end

    irq_enable_reg #(
        .NUM_PERIPH (NUM_PERIPH),
        .REG_W      (REG_W)
    ) u_enable (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (en_wr),
        .wr_data_i   (reg_wdata_i),
        .en_reg_o    (en_reg),
        .periph_en_o (periph_en),
        .global_en_o (global_en)
    );

    irq_status_merge #(
        .NUM_BANKS  (NUM_BANKS),
        .NUM_PERIPH (NUM_PERIPH)
    ) u_merge (
        .clk          (clk),
        .rst_n        (rst_n),
        .bank_pend_i  (bank_pend_i),
        .periph_req_i (periph_req_i),
        .periph_en_i  (periph_en),
        .status_o     (status)
    );

    irq_out_gen #(
        .STAT_W (STAT_W)
    ) u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .global_en_i (global_en),
        .status_i    (status),
        .irq_o       (irq_o)
    );

    // Select the read data for the addressed register.
    always_comb begin
        case (reg_addr_i)
            REG_STATUS: reg_rdata_o = REG_W'(status);
            REG_ENABLE: reg_rdata_o = en_reg;
            default:    reg_rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/irq_aggregator_checker.sv
// Temporal checks for the interrupt status aggregator, attached to the top by bind.
module irq_aggregator_checker
    import irq_agg_pkg::*;
#(
    parameter int NUM_BANKS  = 4,
    parameter int NUM_PERIPH = 6,
    localparam int STAT_W    = NUM_BANKS + NUM_PERIPH
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NUM_BANKS-1:0]  bank_pend_i,
    input logic [NUM_PERIPH-1:0] periph_req_i,
    input logic [NUM_PERIPH-1:0] periph_en,
    input logic                  global_en,
    input logic [STAT_W-1:0]     status,
    input logic                  reg_wr_i,
    input logic [ADDR_W-1:0]     reg_addr_i,
    input logic                  irq_o
);
    // R2 and R10: bank bits follow the bank lines, independent of any enable.
    assert_bank_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> status[NUM_BANKS-1:0] == $past(bank_pend_i));

    // R3: an enabled request shows up in its status bit.
    assert_periph_enabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (periph_req_i[0] && periph_en[0]) |=> status[NUM_BANKS]);

    // R4: a disabled source never sets its status bit.
    assert_periph_disabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (status[STAT_W-1:NUM_BANKS] & ~$past(periph_en)) == '0);

    // R6: a write to the status address leaves the enable state untouched.
    assert_status_write_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && reg_addr_i == REG_STATUS) |=> ($stable(periph_en) && $stable(global_en)));

    // R7: enabled and pending gives an asserted output on the next clock.
    assert_irq_raise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (global_en && status != '0) |=> irq_o);

    // R8: the global enable gates the output.
    assert_irq_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !global_en |=> !irq_o);

    // R9: an empty status word gives a low output on the next clock.
    assert_irq_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (status == '0) |=> !irq_o);
endmodule

bind irq_aggregator irq_aggregator_checker #(
    .NUM_BANKS  (NUM_BANKS),
    .NUM_PERIPH (NUM_PERIPH)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bank_pend_i  (bank_pend_i),
    .periph_req_i (periph_req_i),
    .periph_en    (periph_en),
    .global_en    (global_en),
    .status       (status),
    .reg_wr_i     (reg_wr_i),
    .reg_addr_i   (reg_addr_i),
    .irq_o        (irq_o)
);

// File: tb/irq_aggregator_tb.sv
`timescale 1ns/1ps
module irq_aggregator_tb;
    localparam int NB = 4;
    localparam int NP = 6;
    localparam int RW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NB-1:0] bank_pend = '0;
    logic [NP-1:0] periph_req = '0;
    logic [1:0]    reg_addr = 2'd0;
    logic          reg_wr = 1'b0;
    logic [RW-1:0] reg_wdata = '0;
    logic [RW-1:0] reg_rdata;
    logic          irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    // Scoreboard queues: kind 0 = register read, 1 = irq line.
    int        q_kind[$];
    logic [RW-1:0] q_exp[$];
    string     q_tag[$];

    always #2 clk = ~clk;

    irq_aggregator #(.NUM_BANKS(NB), .NUM_PERIPH(NP), .REG_W(RW)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .bank_pend_i  (bank_pend),
        .periph_req_i (periph_req),
        .reg_addr_i   (reg_addr),
        .reg_wr_i     (reg_wr),
        .reg_wdata_i  (reg_wdata),
        .reg_rdata_o  (reg_rdata),
        .irq_o        (irq)
    );

    // Monitor: shortly after each falling edge, pop and compare queued items.
    always @(negedge clk) begin
        #1;
        while (q_kind.size() > 0) begin
            int        k;
            logic [RW-1:0] e;
            logic [RW-1:0] a;
            string     t;
            k = q_kind.pop_front();
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            a = (k == 0) ? reg_rdata : RW'(irq);
            checks++;
            if (a !== e) begin
                errors++;
                $display("FAIL %s actual 0x%0h expected 0x%0h", t, a, e);
            end
        end
    end

    // Driver helpers: all called at a falling edge.
    task automatic expect_reg(input logic [1:0] addr, input logic [RW-1:0] e, input string tag);
        reg_addr = addr;
        q_kind.push_back(0);
        q_exp.push_back(e);
        q_tag.push_back(tag);
    endtask

    task automatic expect_irq(input logic e, input string tag);
        q_kind.push_back(1);
        q_exp.push_back(RW'(e));
        q_tag.push_back(tag);
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic write_reg(input logic [1:0] addr, input logic [RW-1:0] v);
        reg_addr  = addr;
        reg_wr    = 1'b1;
        reg_wdata = v;
        step(1);
        reg_wr    = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000 && !done) begin
            errors++;
            $display("FAIL watchdog actual %0d expected <=5000 cycles", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1: reset state
        expect_reg(2'd0, 16'h0000, "R1 status after reset");
        step(1);
        expect_reg(2'd1, 16'h0000, "R1 enable after reset");
        expect_irq(1'b0, "R1 irq after reset");
        step(1);

        // R2: banks 0 and 2 pending, global enable still off
        bank_pend = 4'b0101;
        step(1);
        expect_reg(2'd0, 16'h0005, "R2 bank bits");
        step(1);
        expect_irq(1'b0, "R8 irq gated while global enable clear");
        step(1);

        // R7: set global enable only
        write_reg(2'd1, 16'h8000);
        expect_reg(2'd1, 16'h8000, "R5 global enable readback");
        step(1);
        expect_irq(1'b1, "R7 irq raised");
        step(1);

        // R5: write all ones, only writable bits stick
        write_reg(2'd1, 16'hFFFF);
        expect_reg(2'd1, 16'h803F, "R5 unused bits read zero");
        step(1);

        // R3: first and last peripheral, banks quiet
        bank_pend  = 4'b0000;
        periph_req = 6'b100001;
        step(1);
        expect_reg(2'd0, 16'h0210, "R3 peripheral 0 and 5 at bits 4 and 9");
        step(1);

        // R4: disable source 5 while its request stays high
        write_reg(2'd1, 16'h8001);
        step(1);
        expect_reg(2'd0, 16'h0010, "R4 disabled source reads zero");
        step(1);

        // R6: write to status address is ignored
        write_reg(2'd0, 16'h0000);
        expect_reg(2'd0, 16'h0010, "R6 status unchanged after write");
        step(1);
        expect_reg(2'd1, 16'h8001, "R6 enable unchanged after status write");
        step(1);

        // R10: all peripherals disabled, bank 3 pending
        periph_req = 6'b111111;
        bank_pend  = 4'b1000;
        write_reg(2'd1, 16'h8000);
        step(1);
        expect_reg(2'd0, 16'h0008, "R10 bank bit independent of peripheral enables");
        step(1);

        // R9: clear everything, irq drops, then a new event raises it again
        bank_pend  = 4'b0000;
        periph_req = 6'b000000;
        step(1);
        expect_reg(2'd0, 16'h0000, "R9 status cleared");
        step(1);
        expect_irq(1'b0, "R9 irq low after status clears");
        bank_pend = 4'b0001;
        step(1);
        expect_irq(1'b0, "R9 irq still low before new status is seen");
        step(1);
        expect_irq(1'b1, "R9 fresh rising edge on new event");
        step(1);

        // R8: turn global enable off while still pending
        write_reg(2'd1, 16'h0000);
        step(1);
        expect_irq(1'b0, "R8 irq low with global enable clear");
        expect_reg(2'd0, 16'h0001, "R8 status still shows pending");
        step(2);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule